// File: doc/BRIEF.md
# Pressure/Temperature Sensor Register Target on a Two-Wire Serial Bus

This block is the device side of an I2C link for a small environmental sensor. A bus controller addresses it, writes a one-byte register pointer, then writes or reads a run of bytes. The pointer advances after every byte. The register space spans 51 byte addresses, 0x00 to 0x32. Most of it is a fixed snapshot of measurement and calibration data. Four configuration bytes can be changed. A magic write to a control address puts the configuration back to its power-on state.

The bus lines are sampled by the system clock. Each line passes through a two-flop synchronizer and a short majority-free glitch filter before the block looks for edges. The block drives SDA only by pulling it low. START, repeated START and STOP are recognised at any point in a transfer. The pointer outlives STOP and repeated START, so a controller can set the pointer in one transfer and read in the next.

Top module: `sens_i2c_target`

## Requirements
- R1: After reset, SDA is released, `seq_err` is low, and every readable register holds its power-on value. Address 0x08 reads 0xF0, which is its four ready flags in bits 7..4.
- R2: The block acknowledges only its own 7-bit address (parameter, default 0x76) and only in either direction. For any other address it leaves SDA released for the ACK bit and for the rest of the transfer.
- R3: In a write transfer, the pointer is first set to 0xFF and marked unset. The first data byte then loads the pointer. Each later byte is stored at the pointer, after which the pointer increments, wrapping at 8 bits. Every byte after a matching address is acknowledged.
- R4: In a read transfer, each byte is the register at the pointer, sent MSB first, and the pointer increments once per byte sent. Bytes continue while the controller ACKs. After a controller NACK, SDA stays released until the next START or STOP.
- R5: STOP and repeated START leave the pointer unchanged.
- R6: A read transfer that begins with no pointer byte written since the last write address returns 0xFF for every byte. In that case the pointer does not move, and `seq_err` pulses high for exactly one clock.
- R7: Only addresses 0x06, 0x07, 0x08 and 0x09 accept writes. A write aimed at any other address, including 0x33 and above, leaves every register unchanged.
- R8: These addresses read back their register: 0x00–0x09, 0x10–0x21, 0x28 and 0x32. Every other address reads 0xFF.
- R9: Writing 0x09 to address 0x0C restores the power-on values of 0x06–0x09, with 0x08 at 0xF0, and sets the pointer to 0x00. Any other value written to 0x0C has no effect.
- R10: The block changes its SDA drive only while the filtered SCL is low. The one exception is the release forced by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| seq_err | output | 1 | One-clock pulse on a read that starts without a pointer |

## Verification
Most faults in the pointer or in the bit engine are visible at the ports within one byte. A pointer that is off shows up as a wrong data byte in the next read. A miscounted bit shows up as an ACK that lands on a data bit, or as SDA pulled low while the controller owns the line. Those drive windows are watched on every clock. Corruption of the writable configuration stays hidden until it is read back. For that reason, every write test is followed by a read over the same addresses, and the soft-reset tests read the configuration bytes on both sides of the magic write.

// File: rtl/sens_pkg.sv
package sens_pkg;

  localparam int          DATA_W     = 8;
  localparam int          REG_COUNT  = 51;
  localparam int          WR_COUNT   = 4;
  localparam logic [7:0]  WR_BASE    = 8'h06;
  localparam logic [7:0]  CTL_ADDR   = 8'h0C;
  localparam logic [7:0]  CTL_KEY    = 8'h09;
  localparam logic [7:0]  FLAG_ADDR  = 8'h08;
  localparam logic [7:0]  FLAG_VALUE = 8'hF0;
  localparam logic [7:0]  IDLE_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_WAIT
  } bus_st_e;

  // Fixed snapshot contents; unlisted addresses power up as zero.
  function automatic logic [7:0] boot_value(input logic [7:0] a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      8'h00: v = 8'hFE;  8'h01: v = 8'h2F;  8'h02: v = 8'hEE;  8'h03: v = 8'h02;
      8'h04: v = 8'h69;  8'h05: v = 8'hA6;  8'h07: v = 8'h80;  8'h08: v = 8'hC7;
      8'h0D: v = 8'h10;  8'h10: v = 8'h0E;  8'h11: v = 8'h1E;  8'h12: v = 8'hDD;
      8'h13: v = 8'h13;  8'h14: v = 8'hCA;  8'h15: v = 8'h5F;  8'h16: v = 8'h21;
      8'h17: v = 8'h52;  8'h18: v = 8'hF9;  8'h19: v = 8'hC6;  8'h1A: v = 8'h04;
      8'h1B: v = 8'hD1;  8'h1C: v = 8'hDB;  8'h1D: v = 8'h47;  8'h1F: v = 8'h5B;
      8'h20: v = 8'hFB;  8'h21: v = 8'h3A;  8'h24: v = 8'h20;  8'h25: v = 8'h49;
      8'h26: v = 8'h4E;  8'h27: v = 8'hA5;  8'h28: v = 8'h90;  8'h30: v = 8'h60;
      8'h31: v = 8'h15;  8'h32: v = 8'h02;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Value after reset, with the ready-flag override applied.
  function automatic logic [7:0] init_value(input logic [7:0] a);
    return (a == FLAG_ADDR) ? FLAG_VALUE : boot_value(a);
  endfunction

  function automatic logic is_readable(input logic [7:0] a);
    return (a <= 8'h09) || ((a >= 8'h10) && (a <= 8'h21)) ||
           (a == 8'h28) || (a == 8'(REG_COUNT - 1));
  endfunction

endpackage

// File: rtl/sens_line_filter.sv
module sens_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                clean_q, clean_d;
  logic                last_q;

  always_comb begin
    clean_d = clean_q;
    if (&hist_q)       clean_d = 1'b1;
    else if (~|hist_q) clean_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      clean_q <= 1'b1;
      last_q  <= 1'b1;
    end else begin
      sync_q  <= {sync_q[0], raw_in};
      hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      clean_q <= clean_d;
      last_q  <= clean_q;
    end
  end

  assign lvl_o  = clean_q;
  assign rise_o = clean_q & ~last_q;
  assign fall_o = ~clean_q & last_q;

endmodule

// File: rtl/sens_i2c_fsm.sv
module sens_i2c_fsm
  import sens_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h76
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              pull_o,
  output logic              ev_wr_begin,
  output logic              ev_rd_begin,
  output logic              ev_wr_byte,
  output logic              ev_rd_take,
  output logic [DATA_W-1:0] wr_byte
);

  localparam int          CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  bus_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              pull_q, pull_d;
  logic              cont_q, cont_d;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    rw_d        = rw_q;
    pull_d      = pull_q;
    cont_d      = cont_q;
    ev_wr_begin = 1'b0;
    ev_rd_begin = 1'b0;
    ev_wr_byte  = 1'b0;
    ev_rd_take  = 1'b0;
    if (bus_start) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (bus_stop) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == FULL)) begin
            if (st_q == ST_ADDR) begin
              if (sh_q[DATA_W-1:1] == TGT_ADDR) begin
                st_d   = ST_AACK;
                pull_d = 1'b1;
                rw_d   = sh_q[0];
                if (sh_q[0]) ev_rd_begin = 1'b1;
                else         ev_wr_begin = 1'b1;
              end else begin
                st_d = ST_WAIT;
              end
            end else begin
              ev_wr_byte = 1'b1;
              st_d       = ST_WACK;
              pull_d     = 1'b1;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              ev_rd_take = 1'b1;
              sh_d       = rd_byte;
              pull_d     = ~rd_byte[DATA_W-1];
              st_d       = ST_RDAT;
            end else begin
              pull_d = 1'b0;
              st_d   = ST_WDAT;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            st_d   = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == FULL) begin
              pull_d = 1'b0;
              st_d   = ST_RACK;
            end else begin
              sh_d   = {sh_q[DATA_W-2:0], 1'b0};
              pull_d = ~sh_q[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            cont_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (cont_q) begin
              ev_rd_take = 1'b1;
              sh_d       = rd_byte;
              pull_d     = ~rd_byte[DATA_W-1];
              cnt_d      = '0;
              st_d       = ST_RDAT;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      pull_q <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rw_q   <= rw_d;
      pull_q <= pull_d;
      cont_q <= cont_d;
    end
  end

  assign pull_o  = pull_q;
  assign wr_byte = sh_q;

endmodule

// File: rtl/sens_regbank.sv
module sens_regbank
  import sens_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_wr_begin,
  input  logic                       ev_rd_begin,
  input  logic                       ev_wr_byte,
  input  logic                       ev_rd_take,
  input  logic [DATA_W-1:0]          wr_byte,
  output logic [DATA_W-1:0]          rd_byte,
  output logic                       seq_err,
  output logic [DATA_W-1:0]          ptr_o,
  output logic                       ptr_set_o,
  output logic [WR_COUNT*DATA_W-1:0] cfg_view
);

  logic [DATA_W-1:0]               ptr_q, ptr_d;
  logic                            set_q, set_d;
  logic                            err_q, err_d;
  logic                            store_en, soft_rst;
  logic [WR_COUNT-1:0][DATA_W-1:0] cfg_w;
  logic [DATA_W-1:0]               sel;

  assign store_en = ev_wr_byte & set_q;
  assign soft_rst = store_en & (ptr_q == CTL_ADDR) & (wr_byte == CTL_KEY);

  for (genvar g = 0; g < WR_COUNT; g++) begin : g_cfg
    localparam logic [DATA_W-1:0] MY_ADDR = WR_BASE + DATA_W'(g);
    logic              cell_q, cell_en;
    logic [DATA_W-1:0] val_q, val_d;
    assign cell_q  = store_en & (ptr_q == MY_ADDR);
    assign cell_en = cell_q | soft_rst;
    always_comb val_d = soft_rst ? init_value(MY_ADDR) : wr_byte;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= init_value(MY_ADDR);
      else if (cell_en) val_q <= val_d;
    end
    assign cfg_w[g] = val_q;
  end

  always_comb begin
    sel = IDLE_BYTE;
    if (is_readable(ptr_q)) begin
      sel = boot_value(ptr_q);
      for (int k = 0; k < WR_COUNT; k++) begin
        if (ptr_q == (WR_BASE + DATA_W'(k))) sel = cfg_w[k];
      end
    end
    rd_byte = set_q ? sel : IDLE_BYTE;
  end

  always_comb begin
    ptr_d = ptr_q;
    set_d = set_q;
    err_d = 1'b0;
    if (ev_wr_begin) begin
      ptr_d = IDLE_BYTE;
      set_d = 1'b0;
    end else if (ev_rd_begin) begin
      err_d = ~set_q;
    end else if (ev_wr_byte) begin
      if (!set_q) begin
        ptr_d = wr_byte;
        set_d = 1'b1;
      end else if (soft_rst) begin
        ptr_d = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end else if (ev_rd_take && set_q) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      set_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      set_q <= set_d;
      err_q <= err_d;
    end
  end

  assign seq_err   = err_q;
  assign ptr_o     = ptr_q;
  assign ptr_set_o = set_q;
  assign cfg_view  = cfg_w;

endmodule

// File: rtl/sens_i2c_target.sv
module sens_i2c_target
  import sens_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h76,
  parameter int         FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull,
  output logic seq_err
);

  localparam int LINES = 2;
  localparam int SCL_I = 1;
  localparam int SDA_I = 0;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [LINES-1:0] raw_w, lvl_w, rise_w, fall_w;
  logic             scl_c, bus_start, bus_stop;
  logic             ev_wr_begin, ev_rd_begin, ev_wr_byte, ev_rd_take;
  logic [DATA_W-1:0] wr_byte, rd_byte, ptr_w;
  logic             ptr_set_w;
  logic [WR_COUNT*DATA_W-1:0] cfg_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_w[SCL_I] = scl_in;
  assign raw_w[SDA_I] = sda_in;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    sens_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .raw_in (raw_w[i]),
      .lvl_o  (lvl_w[i]),
      .rise_o (rise_w[i]),
      .fall_o (fall_w[i])
    );
  end

  assign scl_c     = lvl_w[SCL_I];
  assign bus_start = fall_w[SDA_I] & scl_c;
  assign bus_stop  = rise_w[SDA_I] & scl_c;

  sens_i2c_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .scl_rise    (rise_w[SCL_I]),
    .scl_fall    (fall_w[SCL_I]),
    .sda_lvl     (lvl_w[SDA_I]),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .rd_byte     (rd_byte),
    .pull_o      (sda_pull),
    .ev_wr_begin (ev_wr_begin),
    .ev_rd_begin (ev_rd_begin),
    .ev_wr_byte  (ev_wr_byte),
    .ev_rd_take  (ev_rd_take),
    .wr_byte     (wr_byte)
  );

  sens_regbank u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ev_wr_begin (ev_wr_begin),
    .ev_rd_begin (ev_rd_begin),
    .ev_wr_byte  (ev_wr_byte),
    .ev_rd_take  (ev_rd_take),
    .wr_byte     (wr_byte),
    .rd_byte     (rd_byte),
    .seq_err     (seq_err),
    .ptr_o       (ptr_w),
    .ptr_set_o   (ptr_set_w),
    .cfg_view    (cfg_view)
  );

endmodule

// File: rtl/sens_i2c_target_chk.sv
module sens_i2c_target_chk
  import sens_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sda_pull,
  input logic                       seq_err,
  input logic                       scl_c,
  input logic                       bus_start,
  input logic                       bus_stop,
  input logic                       ev_wr_begin,
  input logic                       ev_wr_byte,
  input logic                       ev_rd_take,
  input logic [DATA_W-1:0]          wr_byte,
  input logic [DATA_W-1:0]          ptr_w,
  input logic                       ptr_set_w,
  input logic [WR_COUNT*DATA_W-1:0] cfg_view
);

  function automatic logic [WR_COUNT*DATA_W-1:0] cfg_reset_image();
    logic [WR_COUNT*DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < WR_COUNT; k++) v[k*DATA_W +: DATA_W] = init_value(WR_BASE + DATA_W'(k));
    return v;
  endfunction

  logic magic_hit, ro_hit;
  assign magic_hit = ev_wr_byte && ptr_set_w && (ptr_w == CTL_ADDR) && (wr_byte == CTL_KEY);
  assign ro_hit    = ev_wr_byte && ptr_set_w && !magic_hit &&
                     ((ptr_w < WR_BASE) || (ptr_w >= WR_BASE + DATA_W'(WR_COUNT)));

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_c); // R10

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err); // R6

  AST_NOPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_take && !ptr_set_w) |=> $stable(ptr_w)); // R6

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_take && ptr_set_w) |=> (ptr_w == $past(ptr_w) + 8'd1)); // R4

  AST_WR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_begin |=> (ptr_w == IDLE_BYTE && !ptr_set_w)); // R3

  AST_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ro_hit |=> $stable(cfg_view)); // R7

  AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    magic_hit |=> (ptr_w == '0 && cfg_view == cfg_reset_image())); // R9

endmodule

bind sens_i2c_target sens_i2c_target_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_pull    (sda_pull),
  .seq_err     (seq_err),
  .scl_c       (scl_c),
  .bus_start   (bus_start),
  .bus_stop    (bus_stop),
  .ev_wr_begin (ev_wr_begin),
  .ev_wr_byte  (ev_wr_byte),
  .ev_rd_take  (ev_rd_take),
  .wr_byte     (wr_byte),
  .ptr_w       (ptr_w),
  .ptr_set_w   (ptr_set_w),
  .cfg_view    (cfg_view)
);

// File: tb/sim_sens_i2c_target.sv
module sim_sens_i2c_target;

  localparam int         Q   = 10;
  localparam logic [6:0] TGT = 7'h76;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line, sda_pull, seq_err;
  assign sda_line = sda_drv & ~sda_pull;

  sens_i2c_target u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_drv),
    .sda_in   (sda_line),
    .sda_pull (sda_pull),
    .seq_err  (seq_err)
  );

  int checks = 0;
  int fails  = 0;
  int err_seen = 0;
  int stray = 0;
  bit ctl_owns = 1'b0;
  bit done = 1'b0;

  logic [7:0] dflt [0:50] = '{
    8'hFE, 8'h2F, 8'hEE, 8'h02, 8'h69, 8'hA6, 8'h00, 8'h80, 8'hC7, 8'h00, 8'h00, 8'h00,
    8'h00, 8'h10, 8'h00, 8'h00, 8'h0E, 8'h1E, 8'hDD, 8'h13, 8'hCA, 8'h5F, 8'h21, 8'h52,
    8'hF9, 8'hC6, 8'h04, 8'hD1, 8'hDB, 8'h47, 8'h00, 8'h5B, 8'hFB, 8'h3A, 8'h00, 8'h00,
    8'h20, 8'h49, 8'h4E, 8'hA5, 8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h60, 8'h15, 8'h02};
  logic [7:0] mdl [0:50];
  logic [7:0] m_ptr;
  bit         m_set;
  logic [7:0] txq [$];

  // Every-clock monitor: controller-owned windows and error pulses.
  always @(negedge clk) begin
    if (rst_n && seq_err) err_seen++;
    if (ctl_owns && sda_pull) stray++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl_reload();
    for (int i = 0; i < 51; i++) mdl[i] = dflt[i];
    mdl[8] = 8'hF0;
  endtask

  function automatic logic [7:0] m_rd(input logic [7:0] a);
    if ((a <= 8'h09) || (a >= 8'h10 && a <= 8'h21) || a == 8'h28 || a == 8'h32) return mdl[a];
    return 8'hFF;
  endfunction

  task automatic mdl_write(input logic [7:0] d);
    if (m_ptr == 8'h0C && d == 8'h09) begin
      mdl_reload();
      m_ptr = 8'h00;
    end else begin
      if (m_ptr >= 8'h06 && m_ptr <= 8'h09) mdl[m_ptr] = d;
      m_ptr = m_ptr + 8'd1;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_slot(input logic b, input bit own, output logic seen);
    sda_drv = b;
    wait_clk(Q);
    scl_drv = 1'b1;
    ctl_owns = own;
    wait_clk(Q);
    seen = sda_line;
    wait_clk(Q);
    ctl_owns = 1'b0;
    scl_drv = 1'b0;
    wait_clk(Q);
  endtask

  task automatic start_c();
    sda_drv = 1'b1; wait_clk(Q);
    scl_drv = 1'b1; wait_clk(Q);
    sda_drv = 1'b0; wait_clk(Q);
    scl_drv = 1'b0; wait_clk(Q);
  endtask

  task automatic stop_c();
    sda_drv = 1'b0; wait_clk(Q);
    scl_drv = 1'b1; wait_clk(Q);
    sda_drv = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b1, s);
    bit_slot(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, 1'b0, s);
      d[i] = s;
    end
    bit_slot(~give_ack, 1'b0, s);
  endtask

  // Write transfer: pointer byte then the queued data bytes.
  task automatic wr_txn(input logic [7:0] p, input bit do_stop, input string tag);
    logic a;
    start_c();
    send_byte({TGT, 1'b0}, a); chk("R2 write address ack", a, 1);
    m_ptr = 8'hFF; m_set = 1'b0;
    send_byte(p, a); chk({tag, " pointer ack"}, a, 1);
    m_ptr = p; m_set = 1'b1;
    foreach (txq[i]) begin
      send_byte(txq[i], a); chk({tag, " data ack (R3)"}, a, 1);
      mdl_write(txq[i]);
    end
    txq.delete();
    if (do_stop) stop_c();
  endtask

  // Read transfer of n bytes, ending with a controller NACK and STOP.
  task automatic rd_txn(input int n, input string tag);
    logic a;
    logic [7:0] d, e;
    start_c();
    send_byte({TGT, 1'b1}, a); chk("R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      e = m_set ? m_rd(m_ptr) : 8'hFF;
      chk(tag, d, e);
      if (m_set) m_ptr = m_ptr + 8'd1;
    end
    wait_clk(2);
    chk("R4 SDA released after NACK", sda_pull, 0);
    stop_c();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    mdl_reload();
    m_ptr = 8'h00; m_set = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(20);
    chk("R1 SDA released at reset", sda_pull, 0);
    chk("R1 seq_err low at reset", seq_err, 0);

    // R6: read with no pointer ever written
    rd_txn(3, "R6 no-pointer read byte");
    chk("R6 one error pulse", err_seen, 1);

    // R2: foreign address is ignored
    start_c();
    send_byte({7'h50, 1'b0}, a); chk("R2 foreign address NACK", a, 0);
    send_byte(8'h06, a);         chk("R2 silent after foreign address", a, 0);
    stop_c();

    // R1 / R4 / R5: pointer then repeated START read across the low map
    wr_txn(8'h00, 1'b0, "R3");
    rd_txn(12, "R1 R4 R5 sequential read from 0x00");

    // R8: holes and top of the map
    wr_txn(8'h1E, 1'b1, "R3");
    rd_txn(8, "R8 read 0x1E..0x25");
    wr_txn(8'h27, 1'b1, "R3");
    rd_txn(3, "R8 read 0x27..0x29");
    wr_txn(8'h31, 1'b1, "R3");
    rd_txn(3, "R8 read 0x31..0x33");

    // R3 / R7: burst across writable window
    txq = '{8'h55, 8'h11, 8'h22, 8'h33, 8'h44, 8'h66};
    wr_txn(8'h05, 1'b1, "R3");
    wr_txn(8'h04, 1'b1, "R3");
    rd_txn(7, "R3 R7 readback 0x04..0x0A");

    // R7: writes to read-only and out-of-range addresses
    txq = '{8'h77};
    wr_txn(8'h40, 1'b1, "R7");
    txq = '{8'h99};
    wr_txn(8'h10, 1'b1, "R7");
    wr_txn(8'h10, 1'b1, "R3");
    rd_txn(1, "R7 read-only 0x10 unchanged");
    wr_txn(8'h06, 1'b1, "R3");
    rd_txn(4, "R7 config unchanged");

    // R5: pointer kept across STOP and between read transfers
    wr_txn(8'h12, 1'b1, "R5");
    rd_txn(2, "R5 read after STOP");
    rd_txn(1, "R5 pointer continues");

    // R9: wrong key ignored, right key reloads
    txq = '{8'h05};
    wr_txn(8'h0C, 1'b1, "R9");
    wr_txn(8'h06, 1'b1, "R3");
    rd_txn(4, "R9 wrong key ignored");
    txq = '{8'h09};
    wr_txn(8'h0C, 1'b1, "R9");
    rd_txn(10, "R9 reload and pointer zero");

    // R6: address-only write then repeated START read
    start_c();
    send_byte({TGT, 1'b0}, a); chk("R2 write address ack", a, 1);
    m_ptr = 8'hFF; m_set = 1'b0;
    rd_txn(2, "R6 read after pointerless write");
    chk("R6 second error pulse", err_seen, 2);

    chk("R10 no drive in controller windows", stray, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule